// File: doc/BRIEF.md
# Interrupt destination bitmask generator

This block turns an interrupt command into the set of local interrupt units that must receive it. A command is two 32-bit words. The lower word carries a two-bit shorthand, the addressing mode flag and the delivery mode. The upper word carries the 8-bit destination. Each of the N local units presents three values: its 8-bit identifier, a logical destination register whose top byte is the unit's logical ID, and a model register whose top nibble selects flat or cluster logical matching.

When `req_i` is strobed, the block decodes the command against every unit in parallel. It applies the shorthand override and, for lowest-priority delivery, reduces the set to one unit. The result is registered on the next clock edge. `mask_o` then holds that result until the next strobe, and `mask_vld_o` pulses for one cycle to mark each new result. Moving the message on the bus and delivering it to the cores are left to the surrounding logic.

Top module: `dmask_gen`

## Requirements
- R1: The shorthand is taken from `cmd_lo_i[19:18]`. With shorthand 0, the destination is `cmd_hi_i[31:24]` and `cmd_lo_i[11]` selects logical (1) or physical (0) addressing. All other command bits have no effect.
- R2: Shorthand 1 selects only the unit whose index equals `sender_i`.
- R3: Shorthand 2 selects every unit, the sender included.
- R4: Shorthand 3 selects every unit except the sender.
- R5: In physical mode, destination 0xFF selects every unit.
- R6: In physical mode, any other destination selects the lowest-indexed unit whose identifier equals it, or no unit if none does.
- R7: In logical mode, a unit whose model nibble (bits [31:28] of its model register) is 0xF matches when the destination ANDed with its logical ID (bits [31:24] of its logical register) is nonzero.
- R8: In logical mode, a unit whose model nibble is 0x0 matches when the upper nibbles of the destination and the logical ID are equal and the AND of their lower nibbles is nonzero.
- R9: In logical mode, a unit with any other model nibble never matches.
- R10: When the delivery mode `cmd_lo_i[10:8]` is 3'b001 (lowest priority), only the lowest-indexed unit of the selected set remains. An empty set stays empty. This applies to every shorthand.
- R11: The mask appears on `mask_o` at the first clock edge after `req_i` and is held until the next request. `mask_vld_o` is high for exactly that one cycle. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe; the command is decoded in this cycle |
| cmd_lo_i | input | 32 | Lower command word (shorthand, mode flag, delivery mode) |
| cmd_hi_i | input | 32 | Upper command word (destination in the top byte) |
| sender_i | input | IDX_W | Index of the requesting unit |
| unit_id_i | input | N*8 | Per-unit identifiers, unit k in bits [8k+7:8k] |
| unit_ldr_i | input | N*32 | Per-unit logical destination registers, unit k in bits [32k+31:32k] |
| unit_dfr_i | input | N*32 | Per-unit model registers, unit k in bits [32k+31:32k] |
| mask_o | output | N | Registered delivery bitmask, bit k for unit k |
| mask_vld_o | output | 1 | One-cycle pulse marking a fresh mask |

## Verification
Two reductions can act in the same cycle. The shorthand override, or the duplicate-identifier resolution of physical mode, builds a set, and the lowest-priority selection then cuts that set to a single unit. The bench provokes this by sweeping every sender with the all-but-sender shorthand while lowest-priority delivery is on. When unit 0 sends, the target must move to unit 1. It also sweeps all 256 physical destinations with two units sharing an identifier, with lowest priority both on and off. Each result is compared against a set that the bench builds from its own loops, first the whole set and then its lowest bit.

// File: rtl/dmask_pkg.sv
package dmask_pkg;

  localparam int CMD_SH_LSB   = 18;
  localparam int CMD_LOG_BIT  = 11;
  localparam int CMD_DM_LSB   = 8;
  localparam int CMD_DEST_LSB = 24;
  localparam int REG_LID_LSB  = 24;
  localparam int REG_MDL_LSB  = 28;

  localparam logic [7:0] BCAST_ID  = 8'hFF;
  localparam logic [2:0] DM_LOWEST = 3'b001;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [3:0] {
    MDL_CLUSTER = 4'h0,
    MDL_FLAT    = 4'hF
  } model_e;

  function automatic logic flat_hit(input logic [7:0] dest, input logic [7:0] lid);
    return |(dest & lid);
  endfunction

  function automatic logic cluster_hit(input logic [7:0] dest, input logic [7:0] lid);
    return (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
  endfunction

endpackage

// File: rtl/dmask_unit_match.sv
module dmask_unit_match
  import dmask_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] dest_i,
  input  logic [7:0] my_id_i,
  input  logic [7:0] my_lid_i,
  input  logic [3:0] my_model_i,
  output logic       phys_hit_o,
  output logic       log_hit_o
);

  logic model_flat;
  logic model_cluster;

  assign model_flat    = (my_model_i == MDL_FLAT);
  assign model_cluster = (my_model_i == MDL_CLUSTER);

  assign phys_hit_o = (my_id_i == dest_i);

  always_comb begin
    log_hit_o = 1'b0;
    if (model_flat)
      log_hit_o = flat_hit(dest_i, my_lid_i);
    else if (model_cluster)
      log_hit_o = cluster_hit(dest_i, my_lid_i);
  end

  // R9: an unknown model never produces a logical match
  p_unknown_model_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!model_flat && !model_cluster) |-> !log_hit_o);

  // R8: a cluster hit always shares the upper nibble with the destination
  p_cluster_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (model_cluster && log_hit_o) |-> (dest_i[7:4] == my_lid_i[7:4]));

endmodule

// File: rtl/dmask_first_pick.sv
module dmask_first_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] first_o
);

  always_comb begin
    logic seen;
    seen    = 1'b0;
    first_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i] && !seen) begin
        first_o[i] = 1'b1;
        seen       = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmask_gen.sv
module dmask_gen
  import dmask_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [31:0]     cmd_lo_i,
  input  logic [31:0]     cmd_hi_i,
  input  logic [IDX_W-1:0] sender_i,
  input  logic [N*8-1:0]  unit_id_i,
  input  logic [N*32-1:0] unit_ldr_i,
  input  logic [N*32-1:0] unit_dfr_i,
  output logic [N-1:0]    mask_o,
  output logic            mask_vld_o
);

  localparam logic [N-1:0] ALL_UNITS = {N{1'b1}};

  // decoded command fields
  shorthand_e  sh_code;
  logic        logical_mode;
  logic        lowpri_req;
  logic [7:0]  dest_id;
  logic        bcast_dest;

  assign sh_code      = shorthand_e'(cmd_lo_i[CMD_SH_LSB +: 2]);
  assign logical_mode = cmd_lo_i[CMD_LOG_BIT];
  assign lowpri_req   = (cmd_lo_i[CMD_DM_LSB +: 3] == DM_LOWEST);
  assign dest_id      = cmd_hi_i[CMD_DEST_LSB +: 8];
  assign bcast_dest   = (dest_id == BCAST_ID);

  logic cmd_spare_unused;
  assign cmd_spare_unused = ^{cmd_lo_i[31:20], cmd_lo_i[17:12], cmd_lo_i[7:0], cmd_hi_i[23:0]};

  // per-unit matching
  logic [N-1:0] phys_hits;
  logic [N-1:0] log_hits;
  logic [N-1:0] self_vec;

  for (genvar k = 0; k < N; k++) begin : g_unit
    logic tbl_spare_unused;
    assign tbl_spare_unused = ^{unit_ldr_i[k*32 +: REG_LID_LSB], unit_dfr_i[k*32 +: REG_MDL_LSB]};

    dmask_unit_match u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .dest_i    (dest_id),
      .my_id_i   (unit_id_i[k*8 +: 8]),
      .my_lid_i  (unit_ldr_i[k*32 + REG_LID_LSB +: 8]),
      .my_model_i(unit_dfr_i[k*32 + REG_MDL_LSB +: 4]),
      .phys_hit_o(phys_hits[k]),
      .log_hit_o (log_hits[k])
    );

    assign self_vec[k] = (sender_i == IDX_W'(k));
  end

  // physical search: the lowest-indexed matching identifier wins
  logic [N-1:0] phys_one;
  dmask_first_pick #(.W(N)) u_phys_pick (
    .vec_i  (phys_hits),
    .first_o(phys_one)
  );

  logic [N-1:0] dest_mask;
  assign dest_mask = logical_mode ? log_hits : (bcast_dest ? ALL_UNITS : phys_one);

  logic [N-1:0] raw_mask;
  always_comb begin
    unique case (sh_code)
      SH_DEST:   raw_mask = dest_mask;
      SH_SELF:   raw_mask = self_vec;
      SH_ALL:    raw_mask = ALL_UNITS;
      SH_OTHERS: raw_mask = ALL_UNITS & ~self_vec;
      default:   raw_mask = '0;
    endcase
  end

  // lowest-priority reduction
  logic [N-1:0] lowpri_mask;
  dmask_first_pick #(.W(N)) u_lowpri_pick (
    .vec_i  (raw_mask),
    .first_o(lowpri_mask)
  );

  logic [N-1:0] final_mask;
  assign final_mask = lowpri_req ? lowpri_mask : raw_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o     <= '0;
      mask_vld_o <= 1'b0;
    end else begin
      mask_vld_o <= req_i;
      if (req_i)
        mask_o <= final_mask;
    end
  end

  // R11: without a request the mask does not move
  p_hold_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(mask_o));

  // R2: self shorthand yields exactly the sender
  p_self_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && sh_code == SH_SELF) |=> (mask_o == (N'(1) << $past(sender_i))));

  // R3: all-inclusive shorthand fills the mask
  p_all_units_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && sh_code == SH_ALL && !lowpri_req) |=> (mask_o == ALL_UNITS));

  // R4: all-but-sender never includes the sender
  p_excl_sender_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && sh_code == SH_OTHERS) |=> !mask_o[$past(sender_i)]);

  // R6: a non-broadcast physical search targets at most one unit
  p_phys_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && sh_code == SH_DEST && !logical_mode && !bcast_dest) |=> ($countones(mask_o) <= 1));

  // R10: lowest-priority results are one-hot or empty
  p_lowpri_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && lowpri_req) |=> $onehot0(mask_o));

endmodule

// File: tb/dmask_gen_tb.sv
`timescale 1ns/1ps
module dmask_gen_tb;

  localparam int N     = 4;
  localparam int IDX_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_i = 1'b0;
  logic [31:0]     cmd_lo_i = '0;
  logic [31:0]     cmd_hi_i = '0;
  logic [IDX_W-1:0] sender_i = '0;
  logic [N*8-1:0]  unit_id_i = '0;
  logic [N*32-1:0] unit_ldr_i = '0;
  logic [N*32-1:0] unit_dfr_i = '0;
  logic [N-1:0]    mask_o;
  logic            mask_vld_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] ids [N];
  logic [7:0] lids [N];
  logic [3:0] mdls [N];

  always #5 clk = ~clk;

  dmask_gen #(.N(N), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .cmd_lo_i(cmd_lo_i), .cmd_hi_i(cmd_hi_i), .sender_i(sender_i),
    .unit_id_i(unit_id_i), .unit_ldr_i(unit_ldr_i), .unit_dfr_i(unit_dfr_i),
    .mask_o(mask_o), .mask_vld_o(mask_vld_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load_tables();
    for (int k = 0; k < N; k++) begin
      unit_id_i[k*8 +: 8]    = ids[k];
      unit_ldr_i[k*32 +: 32] = {lids[k], 24'h5A5A5A};
      unit_dfr_i[k*32 +: 32] = {mdls[k], 28'hA5A5A5A};
    end
  endtask

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    for (int k = 0; k < N; k++)
      if (v[k]) return N'(1) << k;
    return '0;
  endfunction

  function automatic logic [N-1:0] expect_mask(input int sh, input bit lg, input bit lp,
                                               input logic [7:0] d, input int snd);
    logic [N-1:0] m;
    m = '0;
    case (sh)
      0: begin
        if (!lg) begin
          if (d == 8'hFF) m = '1;
          else
            for (int k = N-1; k >= 0; k--) if (ids[k] == d) m = N'(1) << k;
        end else begin
          for (int k = 0; k < N; k++) begin
            if (mdls[k] == 4'hF) m[k] = (d & lids[k]) != 0;
            else if (mdls[k] == 4'h0)
              m[k] = (d[7:4] == lids[k][7:4]) && ((d[3:0] & lids[k][3:0]) != 0);
          end
        end
      end
      1: m = N'(1) << snd;
      2: m = '1;
      default: m = ~(N'(1) << snd);
    endcase
    return lp ? lowest(m) : m;
  endfunction

  // issue one request; sample at the negedge after the registering edge
  task automatic run(input string tag, input int sh, input bit lg, input bit lp,
                     input logic [7:0] d, input int snd);
    logic [N-1:0] exp;
    exp = expect_mask(sh, lg, lp, d, snd);
    @(negedge clk);
    cmd_lo_i = 32'hFFF0_F0C3 & ~(32'h3 << 18) & ~(32'h1 << 11) & ~(32'h7 << 8);
    cmd_lo_i = cmd_lo_i | (32'(sh) << 18) | (32'(lg) << 11) | ((lp ? 32'h1 : 32'h6) << 8);
    cmd_hi_i = {d, 24'h3C_96E1};
    sender_i = IDX_W'(snd);
    req_i    = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    check({tag, " R11 vld"}, 32'(mask_vld_o), 32'd1);
    check(tag, 32'(mask_o), 32'(exp));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    check("R11 reset mask", 32'(mask_o), 32'd0);
    check("R11 reset vld", 32'(mask_vld_o), 32'd0);
    rst_n = 1'b1;

    // physical search, two units share identifier 0x0A
    ids[0] = 8'h05; ids[1] = 8'h0A; ids[2] = 8'h0A; ids[3] = 8'hFE;
    lids[0] = 8'h01; lids[1] = 8'h82; lids[2] = 8'h31; lids[3] = 8'hFF;
    mdls[0] = 4'hF; mdls[1] = 4'hF; mdls[2] = 4'h0; mdls[3] = 4'h5;
    load_tables();
    for (int d = 0; d < 256; d++) begin
      run(d == 255 ? "R1 R5 phys" : "R1 R6 phys", 0, 1'b0, 1'b0, 8'(d), 3);
      run(d == 255 ? "R5 R10 phys" : "R6 R10 phys", 0, 1'b0, 1'b1, 8'(d), 0);
    end

    // logical config A: flat, flat, cluster, unknown model
    for (int d = 0; d < 256; d++) begin
      run("R1 R7 R8 R9 logical A", 0, 1'b1, 1'b0, 8'(d), 1);
      run("R10 logical A", 0, 1'b1, 1'b1, 8'(d), 1);
    end

    // logical config B: all cluster-style groups plus one unknown model
    lids[0] = 8'h31; lids[1] = 8'h3C; lids[2] = 8'h22; lids[3] = 8'h33;
    mdls[0] = 4'h0; mdls[1] = 4'h0; mdls[2] = 4'h7; mdls[3] = 4'h0;
    load_tables();
    for (int d = 0; d < 256; d++)
      run("R8 R9 logical B", 0, 1'b1, 1'b0, 8'(d), 2);

    // shorthands with every sender, lowest priority on and off
    for (int s = 0; s < N; s++) begin
      run("R2 self", 1, 1'b1, 1'b0, 8'h00, s);
      run("R3 all", 2, 1'b0, 1'b0, 8'h00, s);
      run("R4 others", 3, 1'b0, 1'b0, 8'h00, s);
      run("R2 R10 self", 1, 1'b0, 1'b1, 8'hFF, s);
      run("R3 R10 all", 2, 1'b1, 1'b1, 8'h00, s);
      run("R4 R10 others", 3, 1'b0, 1'b1, 8'hFF, s);
    end

    // hold: change every input without a request
    held = mask_o;
    @(negedge clk);
    cmd_lo_i = 32'h0008_0000;
    cmd_hi_i = 32'hFF00_0000;
    sender_i = IDX_W'(1);
    repeat (3) @(negedge clk);
    check("R11 hold mask", 32'(mask_o), 32'(held));
    check("R11 vld low", 32'(mask_vld_o), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule